// File: doc/BRIEF.md
# Credit-Based Modeled-Time Link

This block models one link of a cycle-level timing model. Between a producer and a consumer it carries two streams that run in opposite directions. The forward stream delivers one optional message per model cycle. The return stream carries one credit count per model cycle. The link has no buffer of its own. Back-pressure comes only from a producer-side credit counter. That counter starts at the modeled depth of the consumer's buffer and is refilled by credits that the consumer hands back.

Each side keeps its own model-cycle count. A side moves on to its next model cycle only when it makes an end-of-cycle call. For the producer this call is a send (valid or invalid) or a pass. For the consumer it is `done` together with a credit count. The forward stream adds `DLAT` model cycles of delay (at least 1). The return stream adds `CLAT` model cycles (0 or 1). With `CLAT = 1` the link is a stall port: a consumer stall reaches the producer's send permission only one model cycle later. With `CLAT = 0` the link is a pipeline port: credits returned in consumer cycle n can already be spent in producer cycle n.

In the requirements below, pn and cn are the number of model cycles that the producer and the consumer have ended since reset. "Credits returned in consumer cycle m" is the `cons_credits` value sampled at that side's end-of-cycle call.

Top module: `credit_link`

## Requirements
- R1: After reset the credit counter equals `DEPTH`. The forward stream holds `DLAT` empty slots, so consumer cycles 0 to DLAT-1 see no message. The return stream holds `CLAT` zero-credit slots.
- R2: `prod_ready` is 1 exactly when pn <= cn - 1 + CLAT. A producer end-of-cycle call is accepted only while `prod_ready` is 1.
- R3: `cons_ready` is 1 exactly when cn <= pn. A consumer `done` is accepted only while `cons_ready` is 1.
- R4: Define avail = min(DEPTH, counter + credits returned in consumer cycle pn-CLAT), taking the credits as 0 when pn < CLAT. Then `prod_can_send` = `prod_ready` and (avail >= 1).
- R5: A producer cycle ends on `prod_enq` or `prod_pass`. When both are high, the send takes priority. After the cycle ends, the counter becomes avail minus 1 if a valid message was accepted, and avail otherwise.
- R6: A valid message accepted in producer cycle n shows on `cons_msg` with `cons_can_recv` = 1 in consumer cycle n+DLAT. A pass or an invalid send leaves `cons_can_recv` = 0 in that consumer cycle.
- R7: Credits returned in consumer cycle m count toward avail in producer cycle m+CLAT.
- R8: A valid send while `prod_ready` = 1 and `prod_can_send` = 0 is a protocol error. `prod_err` is then 1 for exactly the following clock. The message is dropped (its consumer cycle sees no message), the counter is not decremented, and the producer cycle still ends.
- R9: Producer calls made while `prod_ready` = 0, and `done` made while `cons_ready` = 0, have no effect on any state.
- R10: The counter never exceeds `DEPTH`. A credit return that would push it above `DEPTH` saturates at `DEPTH` and counts as an overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| prod_ready | output | 1 | Producer may end its current model cycle |
| prod_can_send | output | 1 | Enough credit for a valid message this model cycle |
| prod_enq | input | 1 | Producer sends and ends its model cycle |
| prod_msg_valid | input | 1 | Message sent with `prod_enq` is valid |
| prod_msg | input | W | Message payload |
| prod_pass | input | 1 | Producer ends its model cycle without sending |
| prod_err | output | 1 | Protocol error pulse; valid send was dropped |
| cons_ready | output | 1 | Consumer may end its current model cycle |
| cons_can_recv | output | 1 | A valid message is present this model cycle |
| cons_msg | output | W | Message payload, zero when none |
| cons_done | input | 1 | Consumer ends its model cycle |
| cons_credits | input | $clog2(DEPTH+1) | Credits returned with `cons_done` |

## Verification
On every clock, the assertions check that the credit counter stays within `DEPTH` and never overflows, that the counter moves only on a producer end-of-cycle, that both permissions are gated by their side's readiness, and that the error pulse matches its cause one clock later. Only the bench's scenarios can show the model-cycle arithmetic: which consumer cycle sees which message, which producer cycle first sees a returned credit, and how far one side may run ahead of the other. The bench covers three configurations, a stall port and a pipeline port with one stage of data delay and a stall port with two stages. In each of them, randomized per-cycle stalls, passes, invalid sends and over-budget sends are compared against a cycle-count model.

// File: rtl/credit_link_pkg.sv
package credit_link_pkg;

  typedef enum logic [1:0] {
    ACT_IDLE,
    ACT_PASS,
    ACT_SEND,
    ACT_DROP
  } prod_act_e;

  function automatic int unsigned cl_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/credit_link_ring.sv
module credit_link_ring
  import credit_link_pkg::*;
#(
  parameter int unsigned TW  = 8,
  parameter int unsigned CAP = 2,
  parameter int unsigned PRE = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [TW-1:0] push_tok,
  input  logic          pop,
  output logic [TW-1:0] head_tok,
  output logic          has_tok,
  output logic          has_room
);
  localparam int unsigned AW = cl_bits(CAP);
  localparam int unsigned NW = $clog2(CAP + 1);

  logic [TW-1:0] slot_q [CAP];
  logic [AW-1:0] rd_q, rd_n, wr_q, wr_n;
  logic [NW-1:0] num_q, num_n;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(CAP - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    rd_n  = pop  ? bump(rd_q) : rd_q;
    wr_n  = push ? bump(wr_q) : wr_q;
    num_n = num_q + NW'(push) - NW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= AW'(PRE % CAP);
      num_q <= NW'(PRE);
    end else begin
      rd_q  <= rd_n;
      wr_q  <= wr_n;
      num_q <= num_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(CAP); i++) slot_q[i] <= '0;
    end else if (push) begin
      slot_q[wr_q] <= push_tok;
    end
  end

  assign head_tok = slot_q[rd_q];
  assign has_tok  = (num_q != '0);
  assign has_room = (num_q != NW'(CAP));

endmodule

// File: rtl/credit_link_acct.sv
module credit_link_acct #(
  parameter int unsigned DEPTH = 2,
  parameter int unsigned CW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          take,
  input  logic [CW-1:0] ret,
  output logic [CW-1:0] avail,
  output logic [CW-1:0] cnt_q,
  output logic          ovf
);
  logic [CW:0]   sum;
  logic [CW-1:0] cnt_n;

  always_comb begin
    sum   = {1'b0, cnt_q} + {1'b0, ret};
    ovf   = (sum > (CW+1)'(DEPTH));
    avail = ovf ? CW'(DEPTH) : sum[CW-1:0];
    cnt_n = step ? (avail - CW'(take)) : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CW'(DEPTH);
    else        cnt_q <= cnt_n;
  end

endmodule

// File: rtl/credit_link.sv
module credit_link
  import credit_link_pkg::*;
#(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 2,
  parameter int unsigned DLAT  = 1,
  parameter int unsigned CLAT  = 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          prod_ready,
  output logic          prod_can_send,
  input  logic          prod_enq,
  input  logic          prod_msg_valid,
  input  logic [W-1:0]  prod_msg,
  input  logic          prod_pass,
  output logic          prod_err,
  output logic          cons_ready,
  output logic          cons_can_recv,
  output logic [W-1:0]  cons_msg,
  input  logic          cons_done,
  input  logic [CW-1:0] cons_credits
);
  localparam int unsigned DCAP = DLAT + 1;
  localparam int unsigned CCAP = CLAT + 1;

  if (DLAT < 1 || CLAT > 1) begin : g_bad_cfg
    $error("credit_link: DLAT must be >= 1 and CLAT must be 0 or 1");
  end

  // reset: asserted asynchronously, released after two clock edges
  logic rs1_q, srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q  <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      rs1_q  <= 1'b1;
      srst_n <= rs1_q;
    end
  end

  logic [W:0]    d_head;
  logic          d_has, d_room;
  logic [CW-1:0] c_head, ret, avail, cnt_q;
  logic          c_has, c_room, ovf;
  prod_act_e     act;
  logic          p_end, c_end, take, err_q, err_n;

  assign prod_ready    = c_has && d_room;
  assign ret           = c_has ? c_head : '0;
  assign prod_can_send = prod_ready && (avail != '0);

  always_comb begin
    act = ACT_IDLE;
    if (prod_ready) begin
      if (prod_enq) begin
        if (!prod_msg_valid)    act = ACT_PASS;
        else if (prod_can_send) act = ACT_SEND;
        else                    act = ACT_DROP;
      end else if (prod_pass) begin
        act = ACT_PASS;
      end
    end
  end

  assign p_end = (act != ACT_IDLE);
  assign take  = (act == ACT_SEND);
  assign err_n = (act == ACT_DROP);

  assign cons_ready    = d_has && c_room;
  assign c_end         = cons_ready && cons_done;
  assign cons_can_recv = cons_ready && d_head[W];
  assign cons_msg      = cons_can_recv ? d_head[W-1:0] : '0;

  credit_link_ring #(.TW(W + 1), .CAP(DCAP), .PRE(DLAT)) u_data (
    .clk      (clk),
    .rst_n    (srst_n),
    .push     (p_end),
    .push_tok ({take, take ? prod_msg : {W{1'b0}}}),
    .pop      (c_end),
    .head_tok (d_head),
    .has_tok  (d_has),
    .has_room (d_room)
  );

  credit_link_ring #(.TW(CW), .CAP(CCAP), .PRE(CLAT)) u_cred (
    .clk      (clk),
    .rst_n    (srst_n),
    .push     (c_end),
    .push_tok (cons_credits),
    .pop      (p_end),
    .head_tok (c_head),
    .has_tok  (c_has),
    .has_room (c_room)
  );

  credit_link_acct #(.DEPTH(DEPTH), .CW(CW)) u_acct (
    .clk   (clk),
    .rst_n (srst_n),
    .step  (p_end),
    .take  (take),
    .ret   (ret),
    .avail (avail),
    .cnt_q (cnt_q),
    .ovf   (ovf)
  );

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) err_q <= 1'b0;
    else         err_q <= err_n;
  end
  assign prod_err = err_q;

endmodule

// File: rtl/credit_link_chk.sv
module credit_link_chk #(
  parameter int unsigned DEPTH = 2,
  parameter int unsigned CW    = 2
) (
  input logic          clk,
  input logic          srst_n,
  input logic          prod_ready,
  input logic          prod_can_send,
  input logic          prod_enq,
  input logic          prod_msg_valid,
  input logic          prod_err,
  input logic          cons_ready,
  input logic          cons_can_recv,
  input logic          p_end,
  input logic [CW-1:0] cnt_q,
  input logic          ovf
);

  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!srst_n)
    p_end |-> !ovf);

  a_r10_cnt_bound: assert property (@(posedge clk) disable iff (!srst_n)
    cnt_q <= CW'(DEPTH));

  a_r5_cnt_moves_on_end: assert property (@(posedge clk) disable iff (!srst_n)
    !p_end |=> $stable(cnt_q));

  a_r4_send_gated: assert property (@(posedge clk) disable iff (!srst_n)
    prod_can_send |-> prod_ready);

  a_r6_recv_gated: assert property (@(posedge clk) disable iff (!srst_n)
    cons_can_recv |-> cons_ready);

  a_r8_err_follows: assert property (@(posedge clk) disable iff (!srst_n)
    (prod_ready && prod_enq && prod_msg_valid && !prod_can_send) |=> prod_err);

  a_r8_err_cause: assert property (@(posedge clk) disable iff (!srst_n)
    (prod_err && $past(srst_n)) |->
      $past(prod_ready && prod_enq && prod_msg_valid && !prod_can_send));

endmodule

bind credit_link credit_link_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk            (clk),
  .srst_n         (srst_n),
  .prod_ready     (prod_ready),
  .prod_can_send  (prod_can_send),
  .prod_enq       (prod_enq),
  .prod_msg_valid (prod_msg_valid),
  .prod_err       (prod_err),
  .cons_ready     (cons_ready),
  .cons_can_recv  (cons_can_recv),
  .p_end          (p_end),
  .cnt_q          (cnt_q),
  .ovf            (ovf)
);

// File: tb/tb_credit_link_lane.sv
module tb_credit_link_lane #(
  parameter int DLAT = 1,
  parameter int CLAT = 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic fin,
  output int   n_tests,
  output int   n_fails
);
  localparam int W     = 8;
  localparam int DEPTH = 2;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int MAXC  = 1024;
  localparam int STEPS = 700;

  logic          prod_ready, prod_can_send, prod_enq, prod_msg_valid, prod_pass, prod_err;
  logic          cons_ready, cons_can_recv, cons_done;
  logic [W-1:0]  prod_msg, cons_msg;
  logic [CW-1:0] cons_credits;

  credit_link #(.W(W), .DEPTH(DEPTH), .DLAT(DLAT), .CLAT(CLAT)) dut (
    .clk(clk), .rst_n(rst_n),
    .prod_ready(prod_ready), .prod_can_send(prod_can_send),
    .prod_enq(prod_enq), .prod_msg_valid(prod_msg_valid), .prod_msg(prod_msg),
    .prod_pass(prod_pass), .prod_err(prod_err),
    .cons_ready(cons_ready), .cons_can_recv(cons_can_recv), .cons_msg(cons_msg),
    .cons_done(cons_done), .cons_credits(cons_credits)
  );

  int       cr [MAXC];
  logic     sv [MAXC];
  logic [7:0] sd [MAXC];
  logic     sboth [MAXC];

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s (DLAT=%0d CLAT=%0d) actual=%0d expected=%0d",
               req, what, DLAT, CLAT, act, exp);
    end
  endtask

  initial begin
    int pn, cn, pcnt, pending, ret, avail;
    bit exp_err, ign, exp_pr, exp_cr, exp_cs, exp_v;
    logic [31:0] r;
    fin = 0; n_tests = 0; n_fails = 0;
    prod_enq = 0; prod_msg_valid = 0; prod_msg = '0; prod_pass = 0;
    cons_done = 0; cons_credits = '0;
    pn = 0; cn = 0; pcnt = DEPTH; pending = 0; exp_err = 0; ign = 0;
    r = 32'h1234_5678 + 32'(DLAT * 16 + CLAT);
    wait (rst_n === 1'b1);
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1", "prod_ready", int'(prod_ready), CLAT);
    chk("R1", "prod_can_send", int'(prod_can_send), CLAT);
    chk("R1", "cons_ready", int'(cons_ready), 1);
    chk("R1", "cons_can_recv", int'(cons_can_recv), 0);
    chk("R1", "prod_err", int'(prod_err), 0);

    for (int step = 0; step < STEPS; step++) begin
      exp_pr = (pn <= cn - 1 + CLAT);
      exp_cr = (cn <= pn);
      ret    = (pn >= CLAT) ? cr[pn - CLAT] : 0;
      avail  = (pcnt + ret > DEPTH) ? DEPTH : pcnt + ret;
      exp_cs = exp_pr && (avail > 0);

      chk(ign ? "R9" : "R2", "prod_ready", int'(prod_ready), int'(exp_pr));
      chk(ign ? "R9" : "R3", "cons_ready", int'(cons_ready), int'(exp_cr));
      chk((ret > 0) ? "R7" : ((avail == DEPTH) ? "R10" : "R4"),
          "prod_can_send", int'(prod_can_send), int'(exp_cs));
      chk("R8", "prod_err", int'(prod_err), int'(exp_err));

      exp_v = 0;
      if (exp_cr) begin
        exp_v = (cn >= DLAT) ? sv[cn - DLAT] : 1'b0;
        chk((cn < DLAT) ? "R1" : ((sboth[cn - DLAT] === 1'b1) ? "R5" : "R6"),
            "cons_can_recv", int'(cons_can_recv), int'(exp_v));
        if (exp_v) chk("R6", "cons_msg", int'(cons_msg), int'(sd[cn - DLAT]));
      end

      // choose stimulus (driven whether or not the side is ready)
      r = r * 32'd1103515245 + 32'd12345;
      prod_msg       = 8'(pn * 37 + step);
      prod_enq       = (r[18:16] <= 3'd5);
      prod_msg_valid = (r[18:16] <= 3'd4);
      prod_pass      = (r[18:16] == 3'd4) || (r[18:16] == 3'd6);
      cons_done      = (r[21:20] != 2'd0);
      if (cons_ready === 1'b1 || exp_cr) begin
        cons_credits = r[22] ? CW'(pending + int'(exp_v)) : '0;
      end else begin
        cons_credits = CW'(r[25:24]);
      end
      ign = (!exp_pr && (prod_enq || prod_pass)) || (!exp_cr && cons_done);

      @(posedge clk);
      // model update from pre-edge state
      exp_err = 0;
      if (exp_pr && (prod_enq || prod_pass)) begin
        sboth[pn] = prod_enq && prod_pass && prod_msg_valid;
        if (prod_enq && prod_msg_valid && exp_cs) begin
          sv[pn] = 1; sd[pn] = prod_msg; pcnt = avail - 1;
        end else begin
          sv[pn] = 0; pcnt = avail;
          exp_err = prod_enq && prod_msg_valid;
        end
        pn++;
      end
      if (exp_cr && cons_done) begin
        cr[cn]  = int'(cons_credits);
        pending = pending + int'(exp_v) - int'(cons_credits);
        cn++;
      end
      @(negedge clk);
      prod_enq = 0; prod_pass = 0; cons_done = 0;
    end

    chk("R2", "producer progressed", int'(pn > STEPS / 8), 1);
    chk("R3", "consumer progressed", int'(cn > STEPS / 8), 1);
    fin = 1;
  end

endmodule

// File: tb/tb_credit_link.sv
module tb_credit_link;
  logic clk;
  logic rst_n;
  logic fin_a, fin_b, fin_c;
  int   t_a, t_b, t_c, f_a, f_b, f_c;
  int   cyc;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial begin
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
  end

  // stall port, pipeline port, stall port with two data stages
  tb_credit_link_lane #(.DLAT(1), .CLAT(1)) lane_a (
    .clk(clk), .rst_n(rst_n), .fin(fin_a), .n_tests(t_a), .n_fails(f_a));
  tb_credit_link_lane #(.DLAT(1), .CLAT(0)) lane_b (
    .clk(clk), .rst_n(rst_n), .fin(fin_b), .n_tests(t_b), .n_fails(f_b));
  tb_credit_link_lane #(.DLAT(2), .CLAT(1)) lane_c (
    .clk(clk), .rst_n(rst_n), .fin(fin_c), .n_tests(t_c), .n_fails(f_c));

  initial begin
    int wd_fail;
    cyc = 0;
    wd_fail = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (fin_a === 1'b1 && fin_b === 1'b1 && fin_c === 1'b1) break;
      if (cyc > 20000) begin
        wd_fail = 1;
        $display("FAIL watchdog expired actual=%0d expected=<20000 cycles", cyc);
        break;
      end
    end
    $display("[TB] %0d tests run, %0d failed",
             t_a + t_b + t_c + wd_fail, f_a + f_b + f_c + wd_fail);
    $finish;
  end

endmodule